// File: doc/BRIEF.md
# PWM Request-to-Load Quantizer

This block turns a PWM request, a period and a high time both given in nanoseconds, into the two reload values of a dual-counter PWM generator. The clock rate of the generator is a parameter. A one-cycle start pulse launches the conversion. The block multiplies each request by the clock rate, then divides it down with a shared restoring divider, one quotient bit per cycle. It then applies a fixed rounding policy, and the result appears together with a one-cycle done pulse.

The policy always rounds down. The chosen period is never longer than the request. A period longer than the generator can count is clamped to the longest one it can produce, and the high time is then scaled by the same ratio. A request shorter than two clock cycles raises a range error and does not round up. The generator outputs a 0% duty cycle whenever its duty reload reaches its period reload, and it cannot produce a high time of one cycle. High-time values that the generator cannot reach are folded onto values it can produce.

Top module: `pwm_load_quantizer`

## Requirements
- R1: After reset, periodLoad and dutyLoad are 0, and done and rangeErr are low.
- R2: The period in cycles is P = floor(reqPeriodNs * CLK_HZ / 10^9), and on success periodLoad = P - 2.
- R3: When the period is not clamped, the high time in cycles is D = floor(reqDutyNs * CLK_HZ / 10^9), and dutyLoad = D - 2 after the folds of R6 and R7.
- R4: If P < 2, done pulses with rangeErr = 1, and periodLoad and dutyLoad keep their previous values. A successful result drives rangeErr to 0.
- R5: If P > MAX_CYC = 2^LOAD_W + 1, then P becomes MAX_CYC and D = floor(reqDutyNs * MAX_CYC / reqPeriodNs). The relative duty cycle is therefore kept.
- R6: If D equals P, D becomes P - 1.
- R7: If D (after R6) is below 2, D becomes P, so dutyLoad equals periodLoad and the generator outputs 0%.
- R8: A reqDutyNs larger than reqPeriodNs is first replaced by reqPeriodNs.
- R9: done is high for exactly one cycle per accepted request. periodLoad, dutyLoad and rangeErr change only in a cycle where done is high, and on success dutyLoad never exceeds periodLoad.
- R10: A start pulse that arrives while a conversion is in progress is ignored. It produces no extra done and does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| reqPeriodNs | input | NS_W | Requested period in ns |
| reqDutyNs | input | NS_W | Requested high time in ns |
| periodLoad | output | LOAD_W | Period reload value (P - 2) |
| dutyLoad | output | LOAD_W | Duty reload value (D - 2) |
| done | output | 1 | One-cycle result strobe |
| rangeErr | output | 1 | Last request was shorter than two cycles |

## Verification
Several folds can act on one request at the same time. A period clamp can combine with the equal-high-time fold when both requests are one million ns: the scaled high time equals MAX_CYC and must drop to MAX_CYC - 1. At the two-cycle floor, a 20 ns request with a 20 ns high time passes through both the equal fold and the below-two fold, and must end with both loads at 0. The bench computes the expected loads from the rules in the requirements and compares them at the done pulse. It also feeds a second start into the middle of a busy conversion and checks that the first result stands and that no second done follows.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PLOAD, ST_PDIV, ST_CHECK, ST_DDIV
  } ctrlState_t;

  typedef struct packed {
    logic capture;    // latch request operands
    logic divStart;   // launch divider
    logic selDuty;    // operand select: 0 period, 1 duty
    logic latchP;     // store period cycles
    logic finishOk;   // publish loads
    logic finishErr;  // publish range error
  } ctrlStrobes_t;
endpackage

// File: rtl/pwmq_divider.sv
module pwmq_divider #(
  parameter int PROD_W = 64,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PROD_W-1:0] dividend,
  input  logic [DIV_W-1:0]  divisor,
  output logic [PROD_W-1:0] quotient,
  output logic              done
);
  localparam int CNT_W = $clog2(PROD_W + 1);

  logic [DIV_W-1:0]  rem;
  logic [PROD_W-1:0] quo;
  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic [DIV_W:0]    shifted;
  logic [DIV_W:0]    diff;
  logic              fits;

  always_comb begin
    shifted = {rem, quo[PROD_W-1]};
    fits    = shifted >= {1'b0, divisor};
    diff    = shifted - {1'b0, divisor};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        quo <= dividend;
        cnt <= CNT_W'(PROD_W);
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? diff[DIV_W-1:0] : shifted[DIV_W-1:0];
        quo <= {quo[PROD_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;
endmodule

// File: rtl/pwmq_ctrl.sv
module pwmq_ctrl
  import pwmq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         divDone,
  input  logic         pSmall,
  output ctrlStrobes_t strobes
);
  ctrlState_t state, nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobes.capture = 1'b1;
        nextState = ST_PLOAD;
      end
      ST_PLOAD: begin
        strobes.divStart = 1'b1;
        nextState = ST_PDIV;
      end
      ST_PDIV: if (divDone) begin
        strobes.latchP = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (pSmall) begin
          strobes.finishErr = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strobes.divStart = 1'b1;
          strobes.selDuty  = 1'b1;
          nextState = ST_DDIV;
        end
      end
      ST_DDIV: begin
        strobes.selDuty = 1'b1;
        if (divDone) begin
          strobes.finishOk = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/pwmq_datapath.sv
module pwmq_datapath
  import pwmq_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int LOAD_W = 16,
  parameter int CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [NS_W-1:0]   reqPeriodNs,
  input  logic [NS_W-1:0]   reqDutyNs,
  output logic              divDone,
  output logic              pSmall,
  output logic [LOAD_W-1:0] periodLoad,
  output logic [LOAD_W-1:0] dutyLoad,
  output logic              done,
  output logic              rangeErr
);
  localparam int CYC_W  = LOAD_W + 1;
  localparam int PROD_W = NS_W + 32;
  localparam logic [CYC_W-1:0] MAX_CYC  = {1'b1, {(LOAD_W-1){1'b0}}, 1'b1};
  localparam logic [31:0]      CLK_K    = 32'(CLK_HZ);
  localparam logic [NS_W-1:0]  NS_PER_S = NS_W'(1_000_000_000);

  logic [NS_W-1:0]   periodNs, dutyNs;
  logic [CYC_W-1:0]  pCyc;
  logic              clamped;
  logic [NS_W-1:0]   opA, opC;
  logic [31:0]       opB;
  logic [PROD_W-1:0] product, quotient;
  logic              qLow, qOver;
  logic [CYC_W-1:0]  dRaw, dFoldEq, dFinal;

  always_comb begin
    opA     = strobes.selDuty ? dutyNs : periodNs;
    opB     = (strobes.selDuty && clamped) ? 32'(MAX_CYC) : CLK_K;
    opC     = (strobes.selDuty && clamped) ? periodNs : NS_PER_S;
    product = PROD_W'(opA) * PROD_W'(opB);
  end

  pwmq_divider #(.PROD_W(PROD_W), .DIV_W(NS_W)) divider (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strobes.divStart),
    .dividend (product),
    .divisor  (opC),
    .quotient (quotient),
    .done     (divDone)
  );

  always_comb begin
    qLow    = quotient < PROD_W'(2);
    qOver   = quotient > PROD_W'(MAX_CYC);
    dRaw    = quotient[CYC_W-1:0];
    dFoldEq = (dRaw == pCyc) ? pCyc - 1'b1 : dRaw;
    dFinal  = (dFoldEq < CYC_W'(2)) ? pCyc : dFoldEq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodNs   <= '0;
      dutyNs     <= '0;
      pCyc       <= '0;
      clamped    <= 1'b0;
      pSmall     <= 1'b0;
      periodLoad <= '0;
      dutyLoad   <= '0;
      done       <= 1'b0;
      rangeErr   <= 1'b0;
    end else begin
      done <= strobes.finishOk | strobes.finishErr;
      if (strobes.capture) begin
        periodNs <= reqPeriodNs;
        dutyNs   <= (reqDutyNs > reqPeriodNs) ? reqPeriodNs : reqDutyNs;
      end
      if (strobes.latchP) begin
        pSmall  <= qLow;
        clamped <= qOver;
        pCyc    <= qOver ? MAX_CYC : quotient[CYC_W-1:0];
      end
      if (strobes.finishOk) begin
        periodLoad <= LOAD_W'(pCyc - CYC_W'(2));
        dutyLoad   <= LOAD_W'(dFinal - CYC_W'(2));
        rangeErr   <= 1'b0;
      end
      if (strobes.finishErr) rangeErr <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_load_quantizer.sv
module pwm_load_quantizer
  import pwmq_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int LOAD_W = 16,
  parameter int CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NS_W-1:0]   reqPeriodNs,
  input  logic [NS_W-1:0]   reqDutyNs,
  output logic [LOAD_W-1:0] periodLoad,
  output logic [LOAD_W-1:0] dutyLoad,
  output logic              done,
  output logic              rangeErr
);
  ctrlStrobes_t strobes;
  logic divDone, pSmall;

  pwmq_ctrl ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .divDone(divDone), .pSmall(pSmall), .strobes(strobes)
  );

  pwmq_datapath #(.NS_W(NS_W), .LOAD_W(LOAD_W), .CLK_HZ(CLK_HZ)) datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqPeriodNs(reqPeriodNs), .reqDutyNs(reqDutyNs),
    .divDone(divDone), .pSmall(pSmall),
    .periodLoad(periodLoad), .dutyLoad(dutyLoad),
    .done(done), .rangeErr(rangeErr)
  );
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker #(
  parameter int LOAD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [LOAD_W-1:0] periodLoad,
  input logic [LOAD_W-1:0] dutyLoad,
  input logic              done,
  input logic              rangeErr
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_duty_not_above_period: assert property (@(posedge clk) disable iff (!rstN)
    (done && !rangeErr) |-> (dutyLoad <= periodLoad));

  a_r9_loads_move_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(periodLoad) || !$stable(dutyLoad)) |-> done);

  a_r9_err_moves_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rangeErr) |-> done);

  a_r4_error_keeps_loads: assert property (@(posedge clk) disable iff (!rstN)
    (done && rangeErr) |-> ($stable(periodLoad) && $stable(dutyLoad)));
endmodule

bind pwm_load_quantizer pwmq_checker #(.LOAD_W(LOAD_W)) chk (
  .clk(clk), .rstN(rstN), .periodLoad(periodLoad), .dutyLoad(dutyLoad),
  .done(done), .rangeErr(rangeErr)
);

// File: tb/pwm_load_quantizer_test.sv
module pwm_load_quantizer_test;
  localparam int NS_W = 32, LOAD_W = 16, CLK_HZ = 100_000_000;
  localparam longint unsigned MAXC = (64'd1 << LOAD_W) + 1;

  logic clk = 0, rstN = 0, start = 0;
  logic [NS_W-1:0] reqPeriodNs = '0, reqDutyNs = '0;
  logic [LOAD_W-1:0] periodLoad, dutyLoad;
  logic done, rangeErr;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  pwm_load_quantizer #(.NS_W(NS_W), .LOAD_W(LOAD_W), .CLK_HZ(CLK_HZ)) uut (.*);

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
      report();
    end
  end

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected result from the requirement rules alone
  task automatic model(input longint unsigned p, input longint unsigned d,
                       output longint unsigned e0, output longint unsigned e1,
                       output bit err);
    longint unsigned pc, dc, dd;
    dd = (d > p) ? p : d;
    pc = p * CLK_HZ / 1000000000;
    err = pc < 2;
    if (pc > MAXC) begin
      dc = dd * MAXC / p;
      pc = MAXC;
    end else dc = dd * CLK_HZ / 1000000000;
    if (dc == pc) dc = pc - 1;
    if (dc < 2) dc = pc;
    e0 = pc - 2;
    e1 = dc - 2;
  endtask

  task automatic pulseStart(input longint unsigned p, input longint unsigned d);
    @(negedge clk);
    reqPeriodNs = NS_W'(p);
    reqDutyNs   = NS_W'(d);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({tag, " done seen"}, done, 1);
  endtask

  // One request, expected loads given; also cross-checked with the model
  task automatic runReq(input string tag, input longint unsigned p, input longint unsigned d,
                        input longint unsigned e0, input longint unsigned e1, input bit eErr);
    longint unsigned m0, m1;
    bit mErr;
    model(p, d, m0, m1, mErr);
    pulseStart(p, d);
    waitDone(tag);
    check({tag, " rangeErr"}, rangeErr, eErr);
    check({tag, " periodLoad"}, periodLoad, e0);
    check({tag, " dutyLoad"}, dutyLoad, e1);
    if (!eErr) begin
      check({tag, " periodLoad vs model"}, periodLoad, m0);
      check({tag, " dutyLoad vs model"}, dutyLoad, m1);
    end
    @(negedge clk);
    check({tag, " R9 done one cycle"}, done, 0);
  endtask

  task automatic testReset();
    check("R1 periodLoad", periodLoad, 0);
    check("R1 dutyLoad", dutyLoad, 0);
    check("R1 done", done, 0);
    check("R1 rangeErr", rangeErr, 0);
  endtask

  task automatic testBusyIgnore();
    bit extra = 0;
    pulseStart(1000, 300);
    repeat (5) @(negedge clk);
    reqPeriodNs = 2000; reqDutyNs = 100; start = 1;
    @(negedge clk);
    start = 0;
    waitDone("R10 busy");
    check("R10 periodLoad", periodLoad, 98);
    check("R10 dutyLoad", dutyLoad, 28);
    @(negedge clk);
    for (int i = 0; i < 250; i++) begin
      if (done) extra = 1;
      @(negedge clk);
    end
    check("R10 no second done", extra, 0);
  endtask

  task automatic testSweep();
    longint unsigned m0, m1;
    bit mErr;
    for (int i = 1; i <= 6; i++) begin
      longint unsigned p = 37 * i * i * i + 13;
      longint unsigned d = (p * i) / 7;
      model(p, d, m0, m1, mErr);
      pulseStart(p, d);
      waitDone("R2 R3 sweep");
      check("R2 sweep rangeErr", rangeErr, mErr);
      if (!mErr) begin
        check("R2 sweep periodLoad", periodLoad, m0);
        check("R3 sweep dutyLoad", dutyLoad, m1);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    runReq("R2 R3 basic", 1000, 300, 98, 28, 0);
    runReq("R2 R3 truncation", 1009, 259, 98, 23, 0);
    runReq("R6 equal fold", 500, 500, 48, 47, 0);
    runReq("R7 short duty fold", 500, 15, 48, 48, 0);
    runReq("R4 below two cycles", 19, 5, 48, 48, 1);
    runReq("R4 zero period", 0, 0, 48, 48, 1);
    runReq("R6 R7 two-cycle floor", 20, 20, 0, 0, 0);
    runReq("R5 clamp scaled", 1000000, 500000, 65535, 32766, 0);
    runReq("R5 R6 clamp full duty", 1000000, 1000000, 65535, 65534, 0);
    runReq("R2 R7 exact max no clamp", 655370, 0, 65535, 65535, 0);
    runReq("R8 duty above period", 1000, 2000, 98, 97, 0);
    testBusyIgnore();
    testSweep();
    report();
  end
endmodule